// File: doc/BRIEF.md
# Registered ROM Read Front End

This block is the read path of a byte-wide read-only memory that gives its data out through an edge-triggered output register. An address comes in on `addr_in`. The address reaches the array either directly or through an address hold stage that is controlled by `ale_in`. On every rising clock edge the word stored at that address is loaded into an 8-bit output register. The output drivers are modelled as a data bus together with a drive-enable flag. A low level on `oe_n_in` enables them. That pin acts either at once, or only after it has been sampled on a clock edge.

Three stored option bits set the behaviour: whether the address hold stage is used, the active level of `ale_in`, and the timing of the output enable. These bits sit in a control byte whose address lies one word above the data range. With `ADDR_W` address bits, the data words occupy 0 to 2^ADDR_W−1 and the control byte is at 2^ADDR_W. For the full 32K × 8 part, `ADDR_W` is 15 and the control byte is at 0x8000. The array has no reset. A single write port loads both the array contents and the control byte, so a bench can initialise the memory.

Top module: `reg_rom_front`

## Requirements
- R1: On every rising edge of `clk`, the output register loads the word stored at the effective read address. When the outputs are enabled, `dout` shows that register from the edge onward.
- R2: While `rst_n` is low, the control byte is 0 and the output register is 0. The control byte therefore selects the direct address path, an active-high `ale_in` and the immediate output enable.
- R3: When control bit 0 is 0, the address goes straight from `addr_in` to the array, and `ale_in` has no effect on the word that is read.
- R4: When control bit 0 is 1 and `ale_in` is at its active level, the read address follows `addr_in`. When `ale_in` is inactive, the read address holds the `addr_in` value sampled at the last rising edge on which `ale_in` was active.
- R5: Control bit 1 sets the active level of `ale_in`: 0 means active high and 1 means active low.
- R6: When control bit 2 is 0, `dout_en` equals the inverse of `oe_n_in` in the same cycle, with no clock edge needed. When `dout_en` is 0, `dout` reads 0 (the high-impedance state).
- R7: When control bit 2 is 1, `oe_n_in` is sampled on each rising edge, and `dout_en` changes only at that edge, to the inverse of the sampled value.
- R8: A write with `wr_addr` bit ADDR_W set loads bits 2..0 of `wr_data` into the control byte and ignores bits 7..3. Any other write stores `wr_data` at word `wr_addr[ADDR_W-1:0]` and leaves the control byte unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Output register clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| addr_in | input | ADDR_W | Read address |
| ale_in | input | 1 | Address hold enable, level set by control bit 1 |
| oe_n_in | input | 1 | Output enable, active low |
| wr_en | input | 1 | Write strobe for the array or the control byte |
| wr_addr | input | ADDR_W+1 | Write address; the top bit selects the control byte |
| wr_data | input | DATA_W | Write data |
| dout | output | DATA_W | Registered read data, 0 while not driven |
| dout_en | output | 1 | Output drivers active |

## Verification
The assertions assume that `oe_n_in`, `ale_in` and `addr_in` change only between clock edges, so that each edge samples one settled value. They also assume that the control byte changes only through the write port. The bench drives every input on the falling edge and makes each control write on a rising edge of its own. Where an assertion compares a value with the cycle before, that value is therefore never caught mid-change. In the hold mode, the bench keeps the address steady across the edge on which `ale_in` goes inactive, so the captured word is the one the bench expects.

// File: rtl/reg_rom_pkg.sv
package reg_rom_pkg;
  typedef struct packed {
    logic sync_oe;   // bit 2
    logic ale_low;   // bit 1
    logic hold_on;   // bit 0
  } rom_cfg_t;

  function automatic rom_cfg_t cfg_from_byte(input logic [7:0] b);
    rom_cfg_t c;
    c.hold_on = b[0];
    c.ale_low = b[1];
    c.sync_oe = b[2];
    return c;
  endfunction

  function automatic logic ale_is_active(input logic ale, input rom_cfg_t c);
    return ale ^ c.ale_low;
  endfunction
endpackage

// File: rtl/rom_addr_path.sv
module rom_addr_path
  import reg_rom_pkg::*;
#(
  parameter int ADDR_W = 10
) (
  input  logic              clk,
  input  logic              rst_n,
  input  rom_cfg_t          cfg,
  input  logic [ADDR_W-1:0] addr_in,
  input  logic              ale_in,
  output logic [ADDR_W-1:0] eff_addr
);
  logic              ale_act;
  logic              holding;
  logic [ADDR_W-1:0] held_q;

  assign ale_act = ale_is_active(ale_in, cfg);
  assign holding = cfg.hold_on && !ale_act;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       held_q <= '0;
    else if (ale_act) held_q <= addr_in;
  end

  assign eff_addr = holding ? held_q : addr_in;

  // R4
  hold_stable_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (holding && $past(holding)) |-> $stable(eff_addr));
endmodule

// File: rtl/rom_array.sv
module rom_array #(
  parameter int ADDR_W = 10,
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              we,
  input  logic [ADDR_W-1:0] waddr,
  input  logic [DATA_W-1:0] wdata,
  input  logic [ADDR_W-1:0] raddr,
  output logic [DATA_W-1:0] rdata
);
  localparam int DEPTH = 1 << ADDR_W;

  logic [DATA_W-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (we) mem[waddr] <= wdata;
  end

  assign rdata = mem[raddr];
endmodule

// File: rtl/rom_out_stage.sv
module rom_out_stage
  import reg_rom_pkg::*;
#(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  rom_cfg_t          cfg,
  input  logic [DATA_W-1:0] rd_word,
  input  logic              oe_n_in,
  output logic [DATA_W-1:0] dout,
  output logic              dout_en
);
  logic [DATA_W-1:0] data_q;
  logic              oe_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      data_q <= '0;
      oe_q   <= 1'b0;
    end else begin
      data_q <= rd_word;
      oe_q   <= !oe_n_in;
    end
  end

  assign dout_en = cfg.sync_oe ? oe_q : !oe_n_in;
  assign dout    = dout_en ? data_q : '0;

  // R7
  sync_oe_edge_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg.sync_oe && $past(cfg.sync_oe)) |-> (dout_en == !$past(oe_n_in)));
endmodule

// File: rtl/reg_rom_front.sv
module reg_rom_front
  import reg_rom_pkg::*;
#(
  parameter int ADDR_W = 10,
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] addr_in,
  input  logic              ale_in,
  input  logic              oe_n_in,
  input  logic              wr_en,
  input  logic [ADDR_W:0]   wr_addr,
  input  logic [DATA_W-1:0] wr_data,
  output logic [DATA_W-1:0] dout,
  output logic              dout_en
);
  rom_cfg_t          cfg_q;
  logic              cfg_we;
  logic              mem_we;
  logic [ADDR_W-1:0] eff_addr;
  logic [DATA_W-1:0] rd_word;

  assign cfg_we = wr_en &&  wr_addr[ADDR_W];
  assign mem_we = wr_en && !wr_addr[ADDR_W];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cfg_q <= '0;
    else if (cfg_we) cfg_q <= cfg_from_byte(wr_data[7:0]);
  end

  rom_addr_path #(.ADDR_W(ADDR_W)) u_addr (
    .clk(clk), .rst_n(rst_n), .cfg(cfg_q),
    .addr_in(addr_in), .ale_in(ale_in), .eff_addr(eff_addr)
  );

  rom_array #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_mem (
    .clk(clk), .we(mem_we), .waddr(wr_addr[ADDR_W-1:0]),
    .wdata(wr_data), .raddr(eff_addr), .rdata(rd_word)
  );

  rom_out_stage #(.DATA_W(DATA_W)) u_out (
    .clk(clk), .rst_n(rst_n), .cfg(cfg_q), .rd_word(rd_word),
    .oe_n_in(oe_n_in), .dout(dout), .dout_en(dout_en)
  );

  // R2
  reset_state_chk: assert property (@(posedge clk)
    !rst_n |-> (cfg_q == '0 && dout == '0));

  // R6
  async_oe_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !cfg_q.sync_oe |-> (dout_en == !oe_n_in));

  // R8
  cfg_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_we |=> (cfg_q == $past(wr_data[2:0])));

  // R8
  cfg_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !cfg_we |=> $stable(cfg_q));
endmodule

// File: tb/reg_rom_front_tb.sv
module reg_rom_front_tb;
  localparam int AW = 10;
  localparam int DW = 8;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic [AW-1:0] addr_in = '0;
  logic          ale_in = 1'b0;
  logic          oe_n_in = 1'b1;
  logic          wr_en = 1'b0;
  logic [AW:0]   wr_addr = '0;
  logic [DW-1:0] wr_data = '0;
  logic [DW-1:0] dout;
  logic          dout_en;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #4 clk = ~clk;

  reg_rom_front #(.ADDR_W(AW), .DATA_W(DW)) u_dut (
    .clk(clk), .rst_n(rst_n), .addr_in(addr_in), .ale_in(ale_in),
    .oe_n_in(oe_n_in), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .dout(dout), .dout_en(dout_en)
  );

  function automatic logic [7:0] pat(input int a);
    return 8'((a * 37 + 5) & 255);
  endfunction

  task automatic check(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic wr(input int a, input int d);
    @(negedge clk);
    wr_en = 1'b1; wr_addr = (AW+1)'(a); wr_data = 8'(d);
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  // stimulus table: {addr, ale, oe_n}; transparent mode, immediate enable
  localparam int NV = 8;
  localparam logic [AW+1:0] VEC [NV] = '{
    {10'h000, 1'b0, 1'b0}, {10'h3FF, 1'b1, 1'b0},
    {10'h155, 1'b0, 1'b1}, {10'h2AA, 1'b1, 1'b0},
    {10'h001, 1'b1, 1'b0}, {10'h200, 1'b0, 1'b0},
    {10'h0F0, 1'b1, 1'b1}, {10'h30C, 1'b0, 1'b0}
  };

  initial begin
    oe_n_in = 1'b0;
    repeat (3) @(negedge clk);
    // R2: defaults in reset, immediate enable active, register cleared
    check("R2 dout_en", dout_en, 1);
    check("R2 dout", dout, 0);
    rst_n = 1'b1;
    for (int a = 0; a < (1 << AW); a++) wr(a, pat(a));

    // R1 R3 R6: table walk
    for (int i = 0; i < NV; i++) begin
      @(negedge clk);
      addr_in = VEC[i][AW+1:2]; ale_in = VEC[i][1]; oe_n_in = VEC[i][0];
      #1 check("R6 immediate enable", dout_en, !VEC[i][0]);
      @(negedge clk);
      check("R1/R3 read data", dout,
            VEC[i][0] ? 0 : pat(int'(VEC[i][AW+1:2])));
    end

    // R4: hold mode, active-high
    wr(1 << AW, 8'h01);
    @(negedge clk); addr_in = 10'h123; ale_in = 1'b1;
    @(negedge clk); check("R4 follow", dout, pat('h123));
    addr_in = 10'h321; ale_in = 1'b0;
    @(negedge clk); check("R4 held", dout, pat('h123));
    addr_in = 10'h0AB;
    @(negedge clk); check("R4 still held", dout, pat('h123));
    ale_in = 1'b1;
    @(negedge clk); check("R4 reopen", dout, pat('h0AB));

    // R5: active-low level
    wr(1 << AW, 8'h03);
    @(negedge clk); addr_in = 10'h044; ale_in = 1'b0;
    @(negedge clk); check("R5 low active follows", dout, pat('h044));
    addr_in = 10'h2F0; ale_in = 1'b1;
    @(negedge clk); check("R5 high holds", dout, pat('h044));

    // R7: sampled enable (oe_n_in currently 0)
    ale_in = 1'b0;
    wr(1 << AW, 8'h04);
    addr_in = 10'h111;
    oe_n_in = 1'b1;
    #1 check("R7 no change before edge", dout_en, 1);
    @(negedge clk); check("R7 disabled at edge", dout_en, 0);
    check("R7 dout quiet", dout, 0);
    oe_n_in = 1'b0;
    #1 check("R7 still disabled", dout_en, 0);
    @(negedge clk); check("R7 enabled at edge", dout_en, 1);
    check("R7 data", dout, pat('h111));

    // R8: upper control bits ignored -> defaults back
    wr(1 << AW, 8'hF8);
    oe_n_in = 1'b1;
    #1 check("R8 upper bits ignored, immediate enable", dout_en, 0);
    oe_n_in = 1'b0; ale_in = 1'b0; addr_in = 10'h222;
    @(negedge clk); check("R8 direct address", dout, pat('h222));
    wr(5, 8'h5A);
    @(negedge clk); addr_in = 10'h005;
    @(negedge clk); check("R8 memory write", dout, 8'h5A);
    addr_in = 10'h000;
    @(negedge clk); check("R8 control write left memory", dout, pat(0));
    done = 1'b1;
  end

  initial begin
    fork
      wait (done);
      begin
        repeat (200000) @(posedge clk);
        checks++; errors++;
        $display("FAIL watchdog: actual timeout expected completion");
      end
    join_any
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule